// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control core of a 64-step digital potentiometer. Three asynchronous control pins arrive from outside the chip: an active-low select, an active-low increment strobe and a direction pin. The block samples them on the system clock and keeps a tap register that picks the wiper position. It steps that register by one on each falling strobe edge and clamps it at both ends. It drives a one-hot select vector for the resistor-array switches.

Releasing the select while the strobe is high saves the current tap into an emulated non-volatile register. That write keeps the block busy for a bounded number of cycles. After every reset, a power-up delay runs first and the saved tap is then recalled into the tap register. The non-volatile register survives ordinary reset and starts from a mid-scale default at power-on.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: The tap code is TAP_W (6) bits wide, and the select vector has exactly one bit set: bit k is high exactly when the tap code equals k.
- R2: While selected (sel_n_i low) and not busy, each high-to-low strobe transition changes the tap by exactly one. Direction high means +1 and direction low means -1. Direction is sampled at each strobe edge and may change while the select stays low.
- R3: An up step at code 63 and a down step at code 0 leave the code unchanged. There is no wraparound.
- R4: A low-to-high select transition while the strobe is high copies the tap into the non-volatile register and holds busy_o high for STORE_CYCLES cycles. A select release while the strobe is low stores nothing and leaves busy_o low.
- R5: While sel_n_i is high, standby_o is high and strobe edges do not change the tap.
- R6: During reset and for PUD_CYCLES cycles after it, busy_o is high and the tap is 0. The non-volatile content is then loaded into the tap. That content is 32 at power-on and is kept across reset.
- R7: Strobe edges and select releases that arrive while busy_o is high (power-up or store) are ignored.
- R8: The pins pass through a two-flop synchroniser plus an edge register. A pin change made between clock edges moves the tap on the third rising edge after it, and moves standby_o on the second.
- R9: If the select rises and the strobe falls in the same sampled cycle, there is neither a step nor a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Asynchronous active-low select |
| strobe_n_i | input | 1 | Asynchronous active-low increment strobe |
| dir_up_i | input | 1 | Asynchronous direction, high = toward the upper terminal |
| tap_o | output | TAP_W | Current tap code |
| wiper_sel_o | output | 2**TAP_W | One-hot wiper switch select |
| busy_o | output | 1 | Power-up recall or store in progress |
| standby_o | output | 1 | Synchronised select is inactive |

## Verification
Two functions can fall into one sampled cycle. In the first case, the select rises and the strobe falls together, which is both a candidate store and a candidate step. In the second case, a strobe edge lands inside the busy window of a store. The bench provokes the first by changing both pins in the same drive call. It provokes the second by reselecting and pulsing the strobe while the store counter runs. In both cases it judges the tap, busy and standby outputs against a behavioural model on every clock. It also makes directed checks that the tap and busy flag stayed put.

// File: rtl/pot_pkg.sv
package pot_pkg;

    typedef enum logic [1:0] {
        PH_POWERUP = 2'd0,
        PH_READY   = 2'd1,
        PH_STORING = 2'd2
    } pot_phase_e;

    typedef struct packed {
        logic sel_n;
        logic strobe_n;
        logic dir_up;
    } pot_pins_t;

    typedef struct packed {
        logic step;
        logic up;
        logic save;
        logic deselected;
    } pot_cmd_t;

    localparam pot_pins_t PINS_IDLE = '{sel_n: 1'b1, strobe_n: 1'b1, dir_up: 1'b0};

    function automatic logic [15:0] sat_step(logic [15:0] cur, logic up, logic [15:0] lim);
        logic [15:0] nxt;
        nxt = cur;
        if (up && (cur != lim))
            nxt = cur + 16'd1;
        else if (!up && (cur != 16'd0))
            nxt = cur - 16'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/pot_pin_sync.sv
module pot_pin_sync
    import pot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pot_pins_t pins_i,
    output pot_cmd_t  cmd_o
);
    pot_pins_t stg [SYNC_STAGES];
    pot_pins_t prev_q;
    pot_pins_t cur;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= PINS_IDLE;
                    else     stg[i] <= pins_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= PINS_IDLE;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign cur = stg[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PINS_IDLE;
        else     prev_q <= cur;
    end

    always_comb begin
        cmd_o.step       = !cur.sel_n && prev_q.strobe_n && !cur.strobe_n;
        cmd_o.up         = cur.dir_up;
        cmd_o.save       = cur.sel_n && !prev_q.sel_n && cur.strobe_n;
        cmd_o.deselected = cur.sel_n;
    end

endmodule

// File: rtl/pot_nv_seq.sv
module pot_nv_seq
    import pot_pkg::*;
#(
    parameter int TAP_W        = 6,
    parameter int NV_DEFAULT   = 32,
    parameter int PUD_CYCLES   = 2000,
    parameter int STORE_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             ready_o,
    output logic             recall_o,
    output logic [TAP_W-1:0] nv_o
);
    localparam int CNT_MAX = (PUD_CYCLES > STORE_CYCLES) ? PUD_CYCLES : STORE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    pot_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAP_W-1:0] nv_q = TAP_W'(NV_DEFAULT);
    logic             store_go;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);
    assign store_go = (phase_q == PH_READY) && save_i;
    assign recall_o = (phase_q == PH_POWERUP) && cnt_done;
    assign ready_o  = (phase_q == PH_READY);
    assign nv_o     = nv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POWERUP;
            cnt_q   <= CNT_W'(PUD_CYCLES - 1);
        end else begin
            unique case (phase_q)
                PH_POWERUP: begin
                    if (cnt_done) phase_q <= PH_READY;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                PH_READY: begin
                    if (store_go) begin
                        phase_q <= PH_STORING;
                        cnt_q   <= CNT_W'(STORE_CYCLES - 1);
                    end
                end
                PH_STORING: begin
                    if (cnt_done) phase_q <= PH_READY;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (store_go && !rst) nv_q <= tap_i;
    end

    p_store_capture_r4: assert property (@(posedge clk) disable iff (rst)
        store_go |=> (phase_q == PH_STORING) && (nv_q == $past(tap_i)));

    p_powerup_busy_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase_q == PH_POWERUP) && !ready_o);

endmodule

// File: rtl/pot_tap_reg.sv
module pot_tap_reg
    import pot_pkg::*;
#(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [TAP_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [TAP_W-1:0] tap_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] tap_stepped;

    assign tap_stepped = TAP_W'(sat_step(16'(tap_q), up_i, 16'(TAP_MAX)));
    assign tap_o = tap_q;

    always_ff @(posedge clk) begin
        if (rst)         tap_q <= '0;
        else if (load_i) tap_q <= load_val_i;
        else if (step_i) tap_q <= tap_stepped;
    end

    p_step_size_r2: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (tap_q == $past(tap_q)) || ({1'b0, tap_q} == {1'b0, $past(tap_q)} + 1'b1)
                    || ({1'b0, tap_q} + 1'b1 == {1'b0, $past(tap_q)}));

    p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i && up_i && tap_q == TAP_MAX) |=> tap_q == TAP_MAX);

    p_no_wrap_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i && !up_i && tap_q == '0) |=> tap_q == '0);

endmodule

// File: rtl/pot_tap_decode.sv
module pot_tap_decode #(
    parameter int TAP_W = 6
) (
    input  logic [TAP_W-1:0]      tap_i,
    output logic [(1<<TAP_W)-1:0] sel_o
);
    localparam int NTAPS = 1 << TAP_W;

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_sw
            assign sel_o[k] = (tap_i == TAP_W'(k));
        end
    endgenerate

endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
    import pot_pkg::*;
#(
    parameter int TAP_W        = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int NV_DEFAULT   = 32,
    parameter int PUD_CYCLES   = 2000,
    parameter int STORE_CYCLES = 1000000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_n_i,
    input  logic                  strobe_n_i,
    input  logic                  dir_up_i,
    output logic [TAP_W-1:0]      tap_o,
    output logic [(1<<TAP_W)-1:0] wiper_sel_o,
    output logic                  busy_o,
    output logic                  standby_o
);
    pot_pins_t        pins;
    pot_cmd_t         cmd;
    logic             ready;
    logic             recall;
    logic [TAP_W-1:0] nv_val;

    assign pins = '{sel_n: sel_n_i, strobe_n: strobe_n_i, dir_up: dir_up_i};

    pot_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .cmd_o  (cmd)
    );

    pot_nv_seq #(
        .TAP_W        (TAP_W),
        .NV_DEFAULT   (NV_DEFAULT),
        .PUD_CYCLES   (PUD_CYCLES),
        .STORE_CYCLES (STORE_CYCLES)
    ) u_nv (
        .clk      (clk),
        .rst      (rst),
        .save_i   (cmd.save),
        .tap_i    (tap_o),
        .ready_o  (ready),
        .recall_o (recall),
        .nv_o     (nv_val)
    );

    pot_tap_reg #(.TAP_W(TAP_W)) u_tap (
        .clk        (clk),
        .rst        (rst),
        .load_i     (recall),
        .load_val_i (nv_val),
        .step_i     (cmd.step && ready),
        .up_i       (cmd.up),
        .tap_o      (tap_o)
    );

    pot_tap_decode #(.TAP_W(TAP_W)) u_dec (
        .tap_i (tap_o),
        .sel_o (wiper_sel_o)
    );

    assign busy_o    = !ready;
    assign standby_o = cmd.deselected;

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(wiper_sel_o) == 1) && wiper_sel_o[tap_o]);

    p_standby_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (standby_o && !recall) |=> $stable(tap_o));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !recall) |=> $stable(tap_o));

endmodule

// File: tb/pot_wiper_ctrl_test.sv
`timescale 1ns/1ps
module pot_wiper_ctrl_test;
    localparam int TAP_W = 6;
    localparam int PUD   = 20;
    localparam int STC   = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, strobe_n = 1'b1, dir_up = 1'b0;
    logic [TAP_W-1:0]      tap;
    logic [(1<<TAP_W)-1:0] wsel;
    logic busy, standby;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pot_wiper_ctrl #(.TAP_W(TAP_W), .PUD_CYCLES(PUD), .STORE_CYCLES(STC)) uut (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .strobe_n_i(strobe_n), .dir_up_i(dir_up),
        .tap_o(tap), .wiper_sel_o(wsel), .busy_o(busy), .standby_o(standby));

    // behavioural reference: pin history {sel_n, strobe_n, dir_up}, newest first
    logic [2:0] hist[$];
    int m_tap = 0, m_nv = 32, m_phase = 0, m_cnt = 0, m_stby = 1;
    bit m_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{3'b110, 3'b110, 3'b110};
            m_phase = 0; m_cnt = PUD - 1; m_tap = 0; m_valid = 1;
        end else begin
            if (m_phase == 1) begin
                if (!hist[1][2] && hist[2][1] && !hist[1][1]) begin
                    if (hist[1][0]) begin if (m_tap < 63) m_tap++; end
                    else begin if (m_tap > 0) m_tap--; end
                end else if (hist[1][2] && !hist[2][2] && hist[1][1]) begin
                    m_nv = m_tap; m_phase = 2; m_cnt = STC - 1;
                end
            end else if (m_phase == 0) begin
                if (m_cnt == 0) begin m_tap = m_nv; m_phase = 1; end else m_cnt--;
            end else begin
                if (m_cnt == 0) m_phase = 1; else m_cnt--;
            end
            hist.push_front({sel_n, strobe_n, dir_up});
            hist = hist[0:2];
        end
        m_stby = hist[1][2];
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R2 tap vs model", int'(tap), m_tap);
            chk("R1 one-hot select", (wsel == ({{((1<<TAP_W)-1){1'b0}},1'b1} << m_tap)) ? 1 : 0, 1);
            chk("R7 busy vs model", int'(busy), (m_phase != 1) ? 1 : 0);
            chk("R5 standby vs model", int'(standby), m_stby);
        end
    end

    task automatic drive(logic c, logic i, logic d);
        @(posedge clk); #1;
        sel_n = c; strobe_n = i; dir_up = d;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(logic up);
        drive(sel_n, 1'b1, up); repeat (3) @(posedge clk);
        drive(sel_n, 1'b0, up); repeat (4) @(posedge clk);
        drive(sel_n, 1'b1, up); repeat (4) @(posedge clk);
    endtask

    initial begin
        settle(1);
        chk("R6 reset tap", int'(tap), 0);
        chk("R6 reset busy", int'(busy), 1);
        chk("R5 reset standby", int'(standby), 1);
        drive(1, 1, 0); rst = 0;
        settle(PUD + 6);
        chk("R6 recall default", int'(tap), 32);
        chk("R6 busy released", int'(busy), 0);

        drive(0, 1, 1); settle(4);
        chk("R5 standby when selected", int'(standby), 0);
        for (int k = 0; k < 3; k++) pulse(1);
        settle(2);
        chk("R2 three up steps", int'(tap), 35);
        pulse(0); settle(2);
        chk("R2 direction change while selected", int'(tap), 34);

        for (int k = 0; k < 35; k++) pulse(1);
        settle(2);
        chk("R3 clamp at top", int'(tap), 63);
        for (int k = 0; k < 70; k++) pulse(0);
        settle(2);
        chk("R3 clamp at bottom", int'(tap), 0);
        chk("R1 bit zero selected", int'(wsel[0]), 1);
        for (int k = 0; k < 5; k++) pulse(1);
        settle(2);
        chk("R2 climb to five", int'(tap), 5);

        drive(1, 1, 1); settle(5);
        chk("R4 store sets busy", int'(busy), 1);
        drive(0, 1, 1);
        pulse(1); pulse(1);
        settle(1);
        chk("R7 steps ignored while storing", int'(tap), 5);
        settle(STC);
        chk("R4 busy ends", int'(busy), 0);

        drive(0, 0, 0); settle(5);
        chk("R2 down step", int'(tap), 4);
        drive(1, 0, 0); settle(6);
        chk("R4 release with strobe low stores nothing", int'(busy), 0);
        chk("R5 standby flag", int'(standby), 1);
        pulse(1); pulse(1); pulse(1);
        settle(2);
        chk("R5 strobes ignored in standby", int'(tap), 4);

        drive(0, 1, 1); settle(6);
        sel_n = sel_n;
        @(posedge clk); #1; sel_n = 1; strobe_n = 0;
        settle(8);
        chk("R9 coincident release and strobe: no step", int'(tap), 4);
        chk("R9 coincident release and strobe: no store", int'(busy), 0);
        drive(1, 1, 1); settle(4);

        drive(1, 1, 1); rst = 1; settle(3);
        chk("R6 tap cleared in reset", int'(tap), 0);
        drive(1, 1, 1); rst = 0;
        settle(PUD + 6);
        chk("R6 stored value recalled after reset", int'(tap), 5);

        drive(0, 1, 1); settle(6);
        drive(0, 0, 1);
        @(negedge clk);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 no change after two edges", int'(tap), 5);
        @(posedge clk); @(negedge clk);
        chk("R8 step on third edge", int'(tap), 6);
        drive(0, 1, 1); settle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule